// File: doc/BRIEF.md
# Decimal-Adjust and Flag-Operation Unit

This unit post-processes an 8-bit accumulator and its flag byte for a small processor datapath. Its main job is the decimal correction applied after a packed-BCD addition or subtraction. It inspects the carry, half-carry and subtract flags and the two digit fields of the accumulator, and from them builds a correction constant. It then adds that constant to the accumulator, or subtracts it when the subtract flag is set. Three simpler operations share the same output path: accumulator complement, carry set and carry complement.

The caller presents one operation per cycle with `in_valid`. The new accumulator and flag byte come out of registers one clock later, marked by `out_valid`, and stay unchanged while no new operation arrives. Flag positions in the flag byte are fixed: carry at bit 0, subtract at bit 1, half-carry at bit 4 and zero at bit 6. The operation takes no account of bits 2, 3, 5 and 7 and passes them through unchanged.

Top module: `bcdu_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted operation, `out_valid`, `a_out` and `f_out` are all zero.
- R2: An operation accepted with `in_valid` high at a rising edge appears on `a_out`/`f_out` with `out_valid` high after that edge. `out_valid` is low after an edge with `in_valid` low, and `a_out`/`f_out` then hold their previous values. The operation codes are 0 decimal adjust, 1 complement accumulator, 2 set carry and 3 complement carry.
- R3: Decimal adjust builds a low correction digit of 6 when the half-carry flag (bit 4) is set or the low nibble of the accumulator is above 9. Otherwise that digit is 0.
- R4: Decimal adjust adds 0x60 to the correction when the carry flag (bit 0) is set or the high nibble of the accumulator is above 9. With the subtract flag clear, it also adds 0x60 when the accumulator is above 0x90 and its low nibble is above 9. The correction is then added to the accumulator, modulo 256.
- R5: With the subtract flag (bit 1) set, decimal adjust subtracts the correction from the accumulator, modulo 256. The extra 0x60 condition of R4 does not apply in this case.
- R6: After decimal adjust, bit 0 holds the carry out of the correcting addition, or the borrow of the subtraction. Bit 4 holds the carry or borrow between the nibbles. Bit 6 is 1 exactly when the new accumulator is zero. Bits 1, 2, 3, 5 and 7 are unchanged.
- R7: Complement accumulator inverts all eight accumulator bits and sets bits 1 and 4 of the flag byte. All other flag bits are unchanged.
- R8: Set carry makes bit 0 one and leaves the accumulator and all other flag bits unchanged.
- R9: Complement carry inverts bit 0 and leaves the accumulator and all other flag bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | Operation code (see R2) |
| a_in | input | 8 | Accumulator before the operation |
| f_in | input | 8 | Flag byte before the operation |
| out_valid | output | 1 | Result registers hold a new result |
| a_out | output | 8 | Accumulator after the operation |
| f_out | output | 8 | Flag byte after the operation |

## Verification
The bench sweeps every accumulator value against all eight combinations of the carry, half-carry and subtract flags. This exercises the digit boundaries at 9/0xA and 0x90/0x9A, where a wrong comparison would apply the correction one value early or late. The sweep also reaches the wrap cases: 0x9A with the subtract flag clear must give zero with carry and zero set, and small values with the subtract flag set must borrow. A design that took the half-carry from the wrong bit, or cleared the pass-through flag bits, would show mismatches on `f_out` across the sweep. Hold cycles check that idle cycles do not disturb the result registers.

// File: rtl/bcdu_pkg.sv
package bcdu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int DIGIT_MAX = 9;

  localparam int FL_C = 0;
  localparam int FL_N = 1;
  localparam int FL_H = 4;
  localparam int FL_Z = 6;

  typedef enum logic [1:0] {
    OP_DADJ = 2'd0,
    OP_CMPL = 2'd1,
    OP_SETC = 2'd2,
    OP_CMPC = 2'd3
  } op_e;
endpackage

// File: rtl/bcdu_corr.sv
module bcdu_corr
  import bcdu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] acc,
  input  logic         flg_c,
  input  logic         flg_h,
  input  logic         flg_n,
  output logic [W-1:0] corr
);
  localparam int NW = NIB_W;
  localparam logic [NW-1:0] DMAX = NW'(DIGIT_MAX);
  localparam logic [NW-1:0] FIX  = NW'(6);

  logic [NW-1:0] lo_dig, hi_dig;
  logic          lo_over, hi_over, add_extra;

  always_comb begin
    lo_dig    = acc[NW-1:0];
    hi_dig    = acc[W-1:W-NW];
    lo_over   = lo_dig > DMAX;
    hi_over   = hi_dig > DMAX;
    // accumulator above 0x90 with an out-of-range low digit
    add_extra = !flg_n && (acc > {DMAX, {NW{1'b0}}}) && lo_over;
    corr      = '0;
    if (flg_h || lo_over)            corr[NW-1:0] = FIX;
    if (flg_c || hi_over || add_extra) corr[W-1:W-NW] = FIX;
  end
endmodule

// File: rtl/bcdu_addsub.sv
module bcdu_addsub
  import bcdu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         hc,
  output logic         zr
);
  localparam int NW = NIB_W;

  logic [W:0]  full;
  logic [NW:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y};
      low  = {1'b0, x[NW-1:0]} - {1'b0, y[NW-1:0]};
    end else begin
      full = {1'b0, x} + {1'b0, y};
      low  = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]};
    end
    res = full[W-1:0];
    cy  = full[W];
    hc  = low[NW];
    zr  = ~|full[W-1:0];
  end
endmodule

// File: rtl/bcdu_unit.sv
module bcdu_unit
  import bcdu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] f_in,
  output logic         out_valid,
  output logic [W-1:0] a_out,
  output logic [W-1:0] f_out
);
  logic [W-1:0] corr, adj_res;
  logic         adj_c, adj_h, adj_z;
  logic [W-1:0] a_nxt, f_nxt;
  logic         v_nxt;
  op_e          op_q;

  bcdu_corr #(.W(W)) u_corr (
    .acc   (a_in),
    .flg_c (f_in[FL_C]),
    .flg_h (f_in[FL_H]),
    .flg_n (f_in[FL_N]),
    .corr  (corr)
  );

  bcdu_addsub #(.W(W)) u_addsub (
    .x   (a_in),
    .y   (corr),
    .sub (f_in[FL_N]),
    .res (adj_res),
    .cy  (adj_c),
    .hc  (adj_h),
    .zr  (adj_z)
  );

  always_comb begin
    op_q  = op_e'(op);
    v_nxt = in_valid;
    a_nxt = a_out;
    f_nxt = f_out;
    if (in_valid) begin
      a_nxt = a_in;
      f_nxt = f_in;
      unique case (op_q)
        OP_DADJ: begin
          a_nxt       = adj_res;
          f_nxt[FL_C] = adj_c;
          f_nxt[FL_H] = adj_h;
          f_nxt[FL_Z] = adj_z;
        end
        OP_CMPL: begin
          a_nxt       = ~a_in;
          f_nxt[FL_H] = 1'b1;
          f_nxt[FL_N] = 1'b1;
        end
        OP_SETC: f_nxt[FL_C] = 1'b1;
        OP_CMPC: f_nxt[FL_C] = ~f_in[FL_C];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      a_out     <= '0;
      f_out     <= '0;
    end else begin
      out_valid <= v_nxt;
      if (in_valid) begin
        a_out <= a_nxt;
        f_out <= f_nxt;
      end
    end
  end

  // R2: result registers hold on idle cycles, valid tracks the request
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(a_out) && $stable(f_out)));
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6: subtract flag passes through the decimal adjust
  p_keep_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0) |=> (f_out[FL_N] == $past(f_in[FL_N])));
  // R7: complement inverts accumulator and sets H and N
  p_cpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1) |=>
      (a_out == ~$past(a_in) && f_out[FL_H] && f_out[FL_N]));
  // R8: set carry
  p_scf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2) |=> (f_out[FL_C] && a_out == $past(a_in)));
  // R9: complement carry
  p_ccf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=>
      (f_out[FL_C] != $past(f_in[FL_C]) && a_out == $past(a_in)));
endmodule

// File: tb/bcdu_unit_bench.sv
`timescale 1ns/1ps
module bcdu_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] op;
  logic [7:0] a_in, f_in;
  logic       out_valid;
  logic [7:0] a_out, f_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bcdu_unit u_bcdu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_in(a_in), .f_in(f_in), .out_valid(out_valid),
    .a_out(a_out), .f_out(f_out)
  );

  // behavioural reference: returns {new_a, new_f}
  function automatic logic [15:0] model(input int opc, input int a, input int f);
    int corr, r, nf, na;
    bit c, h;
    nf = f;
    na = a;
    case (opc)
      0: begin
        corr = 0;
        if (((f >> 4) & 1) == 1 || (a % 16) > 9) corr = 6;
        if ((f & 1) == 1 || (a & 'hF0) > 'h90) corr = corr | 'h60;
        if (((f >> 1) & 1) == 1) begin
          r = a - corr;
          c = (r < 0);
          h = ((a % 16) < (corr % 16));
        end else begin
          if (a > 'h90 && (a % 16) > 9) corr = corr | 'h60;
          r = a + corr;
          c = (r > 255);
          h = ((a % 16) + (corr % 16)) > 15;
        end
        na = (r + 256) % 256;
        nf = (nf & ~'h51) | (c ? 1 : 0) | (h ? 'h10 : 0) | ((na == 0) ? 'h40 : 0);
      end
      1: begin na = (~a) & 255; nf = nf | 'h12; end
      2: nf = nf | 1;
      default: nf = nf ^ 1;
    endcase
    return {8'(na), 8'(nf)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input int opc, input int a, input int f);
    logic [15:0] e;
    string ta, tf;
    e = model(opc, a, f);
    @(negedge clk);
    in_valid = 1'b1; op = 2'(opc); a_in = 8'(a); f_in = 8'(f);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", {7'd0, out_valid}, 8'd1);
    case (opc)
      0: begin
        if (((f >> 1) & 1) == 1) ta = "R5 acc";
        else if ((f & 1) == 1 || a > 'h90) ta = "R4 acc";
        else ta = "R3 acc";
        tf = "R6 flags";
      end
      1: begin ta = "R7 acc"; tf = "R7 flags"; end
      2: begin ta = "R8 acc"; tf = "R8 flags"; end
      default: begin ta = "R9 acc"; tf = "R9 flags"; end
    endcase
    chk(ta, a_out, e[15:8]);
    chk(tf, f_out, e[7:0]);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 2'd0; a_in = 8'h00; f_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {7'd0, out_valid}, 8'd0);
    chk("R1 acc in reset", a_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 acc after reset", a_out, 8'h00);
    chk("R1 flags after reset", f_out, 8'h00);

    // directed boundary points
    apply(0, 'h9A, 'h00);  // wraps to zero with carry
    apply(0, 'h99, 'h00);  // already valid BCD
    apply(0, 'h0A, 'hAC);  // low digit fix, pass-through bits set
    apply(0, 'h00, 'h13);  // subtract with borrow
    // exhaustive sweep of accumulator against C, N, H
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 8; k++)
        apply(0, a, ((k & 1) ? 'h01 : 0) | ((k & 2) ? 'h02 : 0) | ((k & 4) ? 'h10 : 0) | (a & 'hA8));
    for (int i = 0; i < 64; i++) begin
      apply(1, (i * 37) % 256, (i * 91) % 256);
      apply(2, (i * 53) % 256, (i * 29) % 256);
      apply(3, (i * 71) % 256, (i * 13) % 256);
    end

    // R2 hold: idle cycle with changed inputs must not disturb outputs
    apply(1, 'h5C, 'h80);
    @(negedge clk);
    a_in = 8'h11; f_in = 8'hFF; op = 2'd2;
    @(negedge clk);
    chk("R2 idle valid", {7'd0, out_valid}, 8'd0);
    chk("R2 idle acc hold", a_out, 8'hA3);
    chk("R2 idle flags hold", f_out, 8'h92);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule